// File: doc/BRIEF.md
# Integer ALU with Signed and Unsigned Compares

This block is the integer execution unit of a three-operand load/store processor. Each cycle it takes two 32-bit source values, a 5-bit shift distance, a 16-bit immediate with a select that can put the sign-extended immediate in place of the second source, and a 4-bit operation code. It captures one 32-bit result and a zero flag in output registers. The zero flag lets equality branches test the difference of two sources.

The operations are add, subtract, AND, OR, NOR, logical shifts in both directions, set-less-than in signed and unsigned forms, and upper-immediate load. There is no separate NOT operation. To invert a value, NOR it with zero. Add and subtract ignore overflow and wrap.

Inside the top module, a control module decodes the operation code into a small struct of strobes. A datapath module holds the adder, the logic unit, the shifter and the compare logic.

Top module: `intExecUnit`

## Requirements
- R1: While rstN is low, result is 0 and zero is 1.
- R2: The result and zero flag for the inputs present at a rising clock edge appear after that edge and are held until the next edge. zero is 1 exactly when all 32 result bits are 0.
- R3: Operation codes are: 0 add, 1 subtract, 2 AND, 3 OR, 4 NOR, 5 shift left, 6 shift right, 7 signed less-than, 8 unsigned less-than, 9 upper-immediate load. Add gives (A+B) mod 2^32 and subtract gives (A-B) mod 2^32, with no overflow indication.
- R4: AND, OR and NOR act bitwise on A and B. NOR gives the inverse of (A OR B), so NOR with B = 0 gives the bitwise NOT of A.
- R5: Shift left moves A left by shamt places and shift right moves A right by shamt places. In both, the vacated bits are filled with 0.
- R6: Signed less-than gives 1 when A < B as two's-complement values, and 0 otherwise. A = 0xFFFFFFFF with B = 1 gives 1.
- R7: Unsigned less-than compares A and B as unsigned values. A = 0xFFFFFFFF with B = 1 gives 0. Both compare results have bits 31..1 at 0.
- R8: Upper-immediate load puts imm in bits 31..16 and 0 in bits 15..0. It ignores A, B and useImm.
- R9: When useImm is 1, operand B is imm with bit 15 copied into bits 31..16, for every operation that reads B. When useImm is 0, srcB is used.
- R10: Operation codes 10 to 15 give a result of 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| opSel | input | 4 | Operation code |
| srcA | input | 32 | First source operand |
| srcB | input | 32 | Second source operand |
| shamt | input | 5 | Shift distance |
| useImm | input | 1 | Replace B with the sign-extended immediate |
| imm | input | 16 | Immediate constant |
| result | output | 32 | Registered result |
| zero | output | 1 | Registered flag, result equals zero |

## Verification
The bench compares the unit against a bench model using random operands, random operation codes and random immediate selection. This covers every operation, including the undefined codes.

Directed cases target the points where an error would hide:
- operands with opposite signs, which show whether the signed and unsigned compares are kept apart;
- a subtract of equal values and an add that wraps to zero, which raise the zero flag and test the carry path;
- shifts by 0 and by 31, which catch a wrong fill value or a wrong shift direction;
- NOR against zero;
- an upper-immediate load with busy sources, which shows that the sources do not leak into the result.

// File: rtl/aluPkg.sv
package aluPkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_AND  = 4'd2,
    OP_OR   = 4'd3,
    OP_NOR  = 4'd4,
    OP_SLL  = 4'd5,
    OP_SRL  = 4'd6,
    OP_SLT  = 4'd7,
    OP_SLTU = 4'd8,
    OP_LUI  = 4'd9
  } aluOpE;

  typedef enum logic [3:0] {
    SEL_SUM,
    SEL_AND,
    SEL_OR,
    SEL_NOR,
    SEL_SHL,
    SEL_SHR,
    SEL_LESS,
    SEL_UPPER,
    SEL_NONE
  } resultSelE;

  typedef struct packed {
    logic      invertB;
    logic      carryIn;
    logic      lessUnsigned;
    resultSelE resultSel;
  } aluStrobesT;

endpackage

// File: rtl/aluControl.sv
module aluControl
  import aluPkg::*;
(
  input  logic [3:0] opSel,
  output aluStrobesT strobes
);

  always_comb begin
    strobes.invertB      = 1'b0;
    strobes.carryIn      = 1'b0;
    strobes.lessUnsigned = 1'b0;
    strobes.resultSel    = SEL_NONE;
    case (opSel)
      OP_ADD: strobes.resultSel = SEL_SUM;
      OP_SUB: begin
        strobes.invertB   = 1'b1;
        strobes.carryIn   = 1'b1;
        strobes.resultSel = SEL_SUM;
      end
      OP_AND: strobes.resultSel = SEL_AND;
      OP_OR:  strobes.resultSel = SEL_OR;
      OP_NOR: strobes.resultSel = SEL_NOR;
      OP_SLL: strobes.resultSel = SEL_SHL;
      OP_SRL: strobes.resultSel = SEL_SHR;
      OP_SLT: begin
        strobes.invertB   = 1'b1;
        strobes.carryIn   = 1'b1;
        strobes.resultSel = SEL_LESS;
      end
      OP_SLTU: begin
        strobes.invertB      = 1'b1;
        strobes.carryIn      = 1'b1;
        strobes.lessUnsigned = 1'b1;
        strobes.resultSel    = SEL_LESS;
      end
      OP_LUI: strobes.resultSel = SEL_UPPER;
      default: strobes.resultSel = SEL_NONE;
    endcase
  end

endmodule

// File: rtl/aluDatapath.sv
module aluDatapath
  import aluPkg::*;
#(
  parameter int WIDTH = 32,
  parameter int IMMW  = 16,
  localparam int SHW  = $clog2(WIDTH)
) (
  input  aluStrobesT       strobes,
  input  logic [WIDTH-1:0] srcA,
  input  logic [WIDTH-1:0] srcB,
  input  logic [SHW-1:0]   shamt,
  input  logic             useImm,
  input  logic [IMMW-1:0]  imm,
  output logic [WIDTH-1:0] resNext,
  output logic             zeroNext
);

  localparam int EXTW = WIDTH - IMMW;

  logic [WIDTH-1:0] immExt;
  logic [WIDTH-1:0] opB;
  logic [WIDTH-1:0] opBx;
  logic [WIDTH:0]   sumFull;
  logic             carryOut;
  logic             lessSigned;
  logic             lessUns;
  logic             lessBit;
  logic [WIDTH-1:0] norBits;

  assign immExt = {{EXTW{imm[IMMW-1]}}, imm};
  assign opB    = useImm ? immExt : srcB;
  assign opBx   = opB ^ {WIDTH{strobes.invertB}};

  assign sumFull  = {1'b0, srcA} + {1'b0, opBx} + {{WIDTH{1'b0}}, strobes.carryIn};
  assign carryOut = sumFull[WIDTH];

  assign lessUns    = ~carryOut;
  assign lessSigned = (srcA[WIDTH-1] ^ opB[WIDTH-1]) ? srcA[WIDTH-1] : sumFull[WIDTH-1];
  assign lessBit    = strobes.lessUnsigned ? lessUns : lessSigned;

  for (genvar i = 0; i < WIDTH; i++) begin : g_nor
    assign norBits[i] = ~(srcA[i] | opB[i]);
  end

  always_comb begin
    case (strobes.resultSel)
      SEL_SUM:   resNext = sumFull[WIDTH-1:0];
      SEL_AND:   resNext = srcA & opB;
      SEL_OR:    resNext = srcA | opB;
      SEL_NOR:   resNext = norBits;
      SEL_SHL:   resNext = srcA << shamt;
      SEL_SHR:   resNext = srcA >> shamt;
      SEL_LESS:  resNext = {{(WIDTH-1){1'b0}}, lessBit};
      SEL_UPPER: resNext = {imm, {EXTW{1'b0}}};
      default:   resNext = '0;
    endcase
  end

  assign zeroNext = (resNext == '0);

endmodule

// File: rtl/intExecUnit.sv
module intExecUnit
  import aluPkg::*;
#(
  parameter int WIDTH = 32,
  parameter int IMMW  = 16,
  localparam int SHW  = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [3:0]       opSel,
  input  logic [WIDTH-1:0] srcA,
  input  logic [WIDTH-1:0] srcB,
  input  logic [SHW-1:0]   shamt,
  input  logic             useImm,
  input  logic [IMMW-1:0]  imm,
  output logic [WIDTH-1:0] result,
  output logic             zero
);

  aluStrobesT       strobes;
  logic [WIDTH-1:0] resNext;
  logic             zeroNext;

  aluControl u_ctrl (
    .opSel  (opSel),
    .strobes(strobes)
  );

  aluDatapath #(.WIDTH(WIDTH), .IMMW(IMMW)) u_dp (
    .strobes (strobes),
    .srcA    (srcA),
    .srcB    (srcB),
    .shamt   (shamt),
    .useImm  (useImm),
    .imm     (imm),
    .resNext (resNext),
    .zeroNext(zeroNext)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      result <= '0;
      zero   <= 1'b1;
    end else begin
      result <= resNext;
      zero   <= zeroNext;
    end
  end

endmodule

// File: rtl/aluChecker.sv
module aluChecker #(
  parameter int WIDTH = 32,
  parameter int IMMW  = 16,
  localparam int SHW  = $clog2(WIDTH)
) (
  input logic             clk,
  input logic             rstN,
  input logic [3:0]       opSel,
  input logic [WIDTH-1:0] srcA,
  input logic [WIDTH-1:0] srcB,
  input logic [SHW-1:0]   shamt,
  input logic             useImm,
  input logic [IMMW-1:0]  imm,
  input logic [WIDTH-1:0] result,
  input logic             zero
);

  localparam int EXTW = WIDTH - IMMW;

  // R1
  a_r1_reset_state: assert property (@(posedge clk)
    $past(!rstN) |-> (result == '0 && zero));

  // R2
  a_r2_zero_flag: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (zero == (result == '0)));

  // R4
  a_r4_nor_not: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(opSel) == 4'd4 && !$past(useImm) && $past(srcB) == '0)
      |-> (result == ~$past(srcA)));

  // R5
  a_r5_shift_zero: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && ($past(opSel) == 4'd5 || $past(opSel) == 4'd6) && $past(shamt) == '0)
      |-> (result == $past(srcA)));

  // R7
  a_r7_compare_bit: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && ($past(opSel) == 4'd7 || $past(opSel) == 4'd8))
      |-> (result[WIDTH-1:1] == '0));

  // R8
  a_r8_upper_load: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(opSel) == 4'd9)
      |-> (result[EXTW-1:0] == '0 && result[WIDTH-1:EXTW] == $past(imm)));

  // R10
  a_r10_undefined: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(opSel) >= 4'd10) |-> (result == '0 && zero));

endmodule

bind intExecUnit aluChecker #(.WIDTH(WIDTH), .IMMW(IMMW)) u_aluChecker (
  .clk   (clk),
  .rstN  (rstN),
  .opSel (opSel),
  .srcA  (srcA),
  .srcB  (srcB),
  .shamt (shamt),
  .useImm(useImm),
  .imm   (imm),
  .result(result),
  .zero  (zero)
);

// File: tb/test_intExecUnit.sv
`timescale 1ns/1ps
module test_intExecUnit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  opSel = '0;
  logic [31:0] srcA = '0;
  logic [31:0] srcB = '0;
  logic [4:0]  shamt = '0;
  logic        useImm = 1'b0;
  logic [15:0] imm = '0;
  logic [31:0] result;
  logic        zero;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  intExecUnit i_intExecUnit (
    .clk(clk), .rstN(rstN), .opSel(opSel), .srcA(srcA), .srcB(srcB),
    .shamt(shamt), .useImm(useImm), .imm(imm), .result(result), .zero(zero)
  );

  function automatic logic [31:0] expectRes(input logic [3:0] op, input logic [31:0] a,
      input logic [31:0] bIn, input logic [4:0] sh, input logic ui, input logic [15:0] im);
    logic [31:0] b;
    b = ui ? {{16{im[15]}}, im} : bIn;
    case (op)
      4'd0: return a + b;
      4'd1: return a - b;
      4'd2: return a & b;
      4'd3: return a | b;
      4'd4: return ~(a | b);
      4'd5: return a << sh;
      4'd6: return a >> sh;
      4'd7: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      4'd8: return (a < b) ? 32'd1 : 32'd0;
      4'd9: return {im, 16'h0000};
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] exp);
    total++;
    if (result !== exp || zero !== (exp == 32'd0)) begin
      bad++;
      $display("FAIL %s: result=%h zero=%b expected result=%h zero=%b",
               tag, result, zero, exp, (exp == 32'd0));
    end
  endtask

  task automatic apply(input string tag, input logic [3:0] op, input logic [31:0] a,
      input logic [31:0] b, input logic [4:0] sh, input logic ui, input logic [15:0] im);
    @(negedge clk);
    opSel = op; srcA = a; srcB = b; shamt = sh; useImm = ui; imm = im;
    @(posedge clk);
    #1;
    check(tag, expectRes(op, a, b, sh, ui, im));
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog: result=%h expected completion", result);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    // R1: reset state with busy inputs
    opSel = 4'd3; srcA = 32'hFFFF0000; srcB = 32'h0000FFFF;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset", 32'd0);
    @(negedge clk);
    rstN = 1'b1;

    // R3 add / subtract, wrap and zero (R2)
    apply("R3 add", 4'd0, 32'd100, 32'd23, 5'd0, 1'b0, 16'h0);
    apply("R3 add wrap to zero R2", 4'd0, 32'hFFFFFFFF, 32'd1, 5'd0, 1'b0, 16'h0);
    apply("R3 sub equal R2", 4'd1, 32'h12345678, 32'h12345678, 5'd0, 1'b0, 16'h0);
    apply("R3 sub borrow", 4'd1, 32'd1, 32'd2, 5'd0, 1'b0, 16'h0);
    // R4
    apply("R4 and", 4'd2, 32'h00003C00, 32'h00000DC0, 5'd0, 1'b0, 16'h0);
    apply("R4 or", 4'd3, 32'h00003C00, 32'h00000DC0, 5'd0, 1'b0, 16'h0);
    apply("R4 nor with zero is not", 4'd4, 32'h00003C00, 32'h0, 5'd0, 1'b0, 16'h0);
    // R5
    apply("R5 sll 31", 4'd5, 32'h00000003, 32'h0, 5'd31, 1'b0, 16'h0);
    apply("R5 srl 31", 4'd6, 32'hC0000000, 32'h0, 5'd31, 1'b0, 16'h0);
    apply("R5 srl fill", 4'd6, 32'hFFFFFFFF, 32'h0, 5'd4, 1'b0, 16'h0);
    apply("R5 sll 0", 4'd5, 32'hA5A5A5A5, 32'h0, 5'd0, 1'b0, 16'h0);
    // R6 / R7
    apply("R6 signed -1<1", 4'd7, 32'hFFFFFFFF, 32'd1, 5'd0, 1'b0, 16'h0);
    apply("R6 signed 1<-1", 4'd7, 32'd1, 32'hFFFFFFFF, 5'd0, 1'b0, 16'h0);
    apply("R6 signed min<max", 4'd7, 32'h80000000, 32'h7FFFFFFF, 5'd0, 1'b0, 16'h0);
    apply("R7 unsigned big<1", 4'd8, 32'hFFFFFFFF, 32'd1, 5'd0, 1'b0, 16'h0);
    apply("R7 unsigned 1<big", 4'd8, 32'd1, 32'hFFFFFFFF, 5'd0, 1'b0, 16'h0);
    apply("R7 unsigned equal", 4'd8, 32'd7, 32'd7, 5'd0, 1'b0, 16'h0);
    // R8
    apply("R8 upper load", 4'd9, 32'hFFFFFFFF, 32'hFFFFFFFF, 5'd7, 1'b1, 16'h007D);
    // R9
    apply("R9 add negative imm", 4'd0, 32'd5, 32'd1000, 5'd0, 1'b1, 16'hFFFF);
    apply("R9 slt imm", 4'd7, 32'hFFFFFFFE, 32'd0, 5'd0, 1'b1, 16'hFFFF);
    apply("R9 sltu imm", 4'd8, 32'hFFFFFFFE, 32'd0, 5'd0, 1'b1, 16'hFFFF);
    // R10
    apply("R10 code 10", 4'd10, 32'hFFFFFFFF, 32'h1, 5'd3, 1'b0, 16'h1);
    apply("R10 code 15", 4'd15, 32'h12345678, 32'h9, 5'd1, 1'b1, 16'h8000);

    // Random mix covering R2..R10
    for (int n = 0; n < 400; n++) begin
      logic [3:0]  rop;
      logic [31:0] ra, rb;
      rop = 4'($urandom_range(0, 15));
      ra = $urandom();
      rb = ($urandom_range(0, 7) == 0) ? ra : $urandom();
      apply("R3 random", rop, ra, rb, 5'($urandom_range(0, 31)),
            1'($urandom_range(0, 1)), 16'($urandom()));
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule